// File: doc/BRIEF.md
# Low-Frequency Transponder Downlink Encoder

This block produces the reader-to-tag command stream for a 125 kHz read/write transponder by keying the carrier field on and off. One pulse on `start` captures a command: the kind of operation (write a block, read a block, or read the trace page), an optional 32-bit password, 32 bits of write data and a 3-bit block number. The block then plays out the whole frame on `field_en`. A long field-off start gap comes first. Each bit follows as a field-on interval whose length gives the bit value, and a fixed field-off gap follows every bit.

A write frame ends with the field held on long enough for the tag to program its memory. The field then drops and `done` pulses. A read frame ends with the field on for a settle window. `done` then pulses to say that sampling of the tag's reply may begin, and the field stays on until the next command starts. All timing is counted in field clocks. A field clock is a fixed number of system clocks, set by a divider parameter.

Top module: `lf_downlink_enc`

## Requirements
- R1: During and after reset, `field_en`, `busy` and `done` are all 0.
- R2: When a command is accepted, `busy` is 1 from the next cycle and `field_en` is held at 0 for START_FC field clocks (default 248). This happens even if the field was on before.
- R3: Each frame bit is a field-on interval of ZERO_FC field clocks (default 144) for a 0 or ONE_FC (default 400) for a 1. A field-off gap of GAP_FC field clocks (default 160) follows every bit, the last bit included.
- R4: `cmd_op` encodes the operation as 0 for block write, 1 for block read and 2 for trace-page read. Write and block read open with bits 1 then 0. A trace-page read sends only the bits 1 then 1.
- R5: For write and block read with `pw_en`=1, the 32-bit `pw_value` follows the opcode, most significant bit first. For a trace-page read, `pw_en` has no effect on the frame.
- R6: For write and block read, a single 0 bit comes next. For a write, the 32 bits of `wr_data` follow it, MSB first. Both frames end with the 3 bits of `blk_addr`, MSB first.
- R7: After the last gap of a write frame, the field is on for HOLD_FC field clocks (default 2500, 20 ms). `field_en` then returns to 0 on the same edge that raises `done`.
- R8: After the last gap of a read frame (block or trace), the field is on for SETTLE_FC field clocks (default 416). `done` is then raised while `field_en` stays 1, and it stays 1 while idle until the next accepted command.
- R9: One field clock lasts DIV system clocks (default 192). Every interval lasts exactly its field-clock count times DIV, measured from the edge on which the command was accepted.
- R10: A `start` pulse while `busy` is 1 is ignored. Command inputs are captured at acceptance, so later changes to them do not alter the frame in progress.
- R11: A `start` with `cmd_op`=3 is not accepted: `busy` stays 0 and `field_en` keeps its level.
- R12: `done` is a one-cycle pulse, and `busy` is 0 in the cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted when idle |
| cmd_op | input | 2 | Operation: 0 write, 1 block read, 2 trace read, 3 reserved |
| pw_en | input | 1 | Insert password after the opcode |
| pw_value | input | 32 | Password |
| wr_data | input | 32 | Block data for a write |
| blk_addr | input | 3 | Block number |
| field_en | output | 1 | Registered carrier enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
All internal state of this block shows on one wire, `field_en`, as run lengths. Any wrong count, bit selection or state step therefore shows up as a pulse or gap of the wrong length within one field-clock interval of the fault. The bench decodes each field-on run back into a bit and checks every gap length. It also checks the final hold or settle length and the field level at `done`. An error in the divider stretches every run by the same factor, which shows on the very first start gap. A frame built from the wrong fields, or from inputs that changed after acceptance, shows up as a differing decoded bit string or bit count at the end of the frame.

// File: rtl/lfdl_pkg.sv
package lfdl_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_TRACE = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SGAP,
    S_ON,
    S_GAP,
    S_HOLD,
    S_SETTLE
  } state_e;

  // opcode 2 + password 32 + lock 1 + data 32 + block 3
  localparam int FRAME_MAX = 70;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lfdl_tick.sv
module lfdl_tick #(
  parameter int DIV = 192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_spacing
      // R9
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/lfdl_frame.sv
module lfdl_frame
  import lfdl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [1:0]  op,
  input  logic        pen,
  input  logic [31:0] pw,
  input  logic [31:0] data,
  input  logic [2:0]  blk,
  input  logic        shift,
  output logic        cur_bit,
  output logic        empty,
  output logic        is_write
);
  logic [FRAME_MAX-1:0] sreg;
  logic [LEN_W-1:0]     rem;
  logic [FRAME_MAX-1:0] build_vec;
  logic [LEN_W-1:0]     build_len;

  // right-aligned assembly, then left-justified into the shifter
  always_comb begin
    build_vec = '0;
    build_len = '0;
    if (op == OP_TRACE) begin
      build_vec = FRAME_MAX'(2'b11);
      build_len = LEN_W'(2);
    end else begin
      build_vec = FRAME_MAX'(2'b10);
      build_len = LEN_W'(2);
      if (pen) begin
        build_vec = (build_vec << 32) | FRAME_MAX'(pw);
        build_len = build_len + LEN_W'(32);
      end
      build_vec = build_vec << 1;
      build_len = build_len + LEN_W'(1);
      if (op == OP_WRITE) begin
        build_vec = (build_vec << 32) | FRAME_MAX'(data);
        build_len = build_len + LEN_W'(32);
      end
      build_vec = (build_vec << 3) | FRAME_MAX'(blk);
      build_len = build_len + LEN_W'(3);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg     <= '0;
      rem      <= '0;
      is_write <= 1'b0;
    end else if (load) begin
      sreg     <= build_vec << (LEN_W'(FRAME_MAX) - build_len);
      rem      <= build_len;
      is_write <= (op == OP_WRITE);
    end else if (shift && rem != '0) begin
      sreg <= sreg << 1;
      rem  <= rem - 1'b1;
    end
  end

  assign cur_bit = sreg[FRAME_MAX-1];
  assign empty   = (rem == '0);

  // R4
  frame_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !empty);

  // R6
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rem <= LEN_W'(FRAME_MAX));

endmodule

// File: rtl/lf_downlink_enc.sv
module lf_downlink_enc
  import lfdl_pkg::*;
#(
  parameter int DIV       = 192,
  parameter int START_FC  = 248,
  parameter int GAP_FC    = 160,
  parameter int ZERO_FC   = 144,
  parameter int ONE_FC    = 400,
  parameter int HOLD_FC   = 2500,
  parameter int SETTLE_FC = 416
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  cmd_op,
  input  logic        pw_en,
  input  logic [31:0] pw_value,
  input  logic [31:0] wr_data,
  input  logic [2:0]  blk_addr,
  output logic        field_en,
  output logic        busy,
  output logic        done
);
  localparam int MAXD = max2(max2(max2(START_FC, GAP_FC), max2(ZERO_FC, ONE_FC)),
                             max2(HOLD_FC, SETTLE_FC));
  localparam int TW   = $clog2(MAXD + 1);

  state_e          st;
  logic [TW-1:0]   remain;
  logic            tick, expire, accept;
  logic            fr_bit, fr_empty, fr_write, fr_shift;

  assign accept   = start && (st == S_IDLE) && (cmd_op != OP_RSVD);
  assign expire   = tick && (remain == TW'(1));
  assign fr_shift = (st == S_ON) && expire;
  assign busy     = (st != S_IDLE);

  lfdl_tick #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .tick  (tick)
  );

  lfdl_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .op       (cmd_op),
    .pen      (pw_en),
    .pw       (pw_value),
    .data     (wr_data),
    .blk      (blk_addr),
    .shift    (fr_shift),
    .cur_bit  (fr_bit),
    .empty    (fr_empty),
    .is_write (fr_write)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      remain   <= '0;
      field_en <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st != S_IDLE && tick) remain <= remain - 1'b1;
      case (st)
        S_IDLE: if (accept) begin
          st       <= S_SGAP;
          remain   <= TW'(START_FC);
          field_en <= 1'b0;
        end
        S_SGAP: if (expire) begin
          st       <= S_ON;
          remain   <= fr_bit ? TW'(ONE_FC) : TW'(ZERO_FC);
          field_en <= 1'b1;
        end
        S_ON: if (expire) begin
          st       <= S_GAP;
          remain   <= TW'(GAP_FC);
          field_en <= 1'b0;
        end
        S_GAP: if (expire) begin
          field_en <= 1'b1;
          if (!fr_empty) begin
            st     <= S_ON;
            remain <= fr_bit ? TW'(ONE_FC) : TW'(ZERO_FC);
          end else if (fr_write) begin
            st     <= S_HOLD;
            remain <= TW'(HOLD_FC);
          end else begin
            st     <= S_SETTLE;
            remain <= TW'(SETTLE_FC);
          end
        end
        S_HOLD: if (expire) begin
          st       <= S_IDLE;
          field_en <= 1'b0;
          done     <= 1'b1;
        end
        S_SETTLE: if (expire) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !field_en);

  // R7
  write_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && expire) |=> (done && !field_en));

  // R8
  read_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE && expire) |=> (done && field_en));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(st inside {S_HOLD, S_SETTLE})) |=> busy);

endmodule

// File: tb/tb_lf_downlink_enc.sv
`timescale 1ns/1ps
module tb_lf_downlink_enc;
  localparam int DIV = 2, SG = 6, GP = 3, Z0 = 2, O1 = 5, HD = 10, ST = 4;

  typedef struct packed {
    logic [1:0]  op;
    logic        pen;
    logic [31:0] pw;
    logic [31:0] data;
    logic [2:0]  blk;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 32'h0000_0000, 32'hA5C3_0F96, 3'd5},
    '{2'd0, 1'b1, 32'h8000_0001, 32'hFFFF_0000, 3'd7},
    '{2'd1, 1'b0, 32'h0000_0000, 32'h1111_1111, 3'd2},
    '{2'd1, 1'b1, 32'h1234_5678, 32'h0000_0000, 3'd0},
    '{2'd2, 1'b1, 32'hDEAD_BEEF, 32'hCAFE_F00D, 3'd6}
  };

  logic clk = 0, rst_n = 0, start = 0, pw_en = 0;
  logic [1:0] cmd_op = 0;
  logic [31:0] pw_value = 0, wr_data = 0;
  logic [2:0] blk_addr = 0;
  logic field_en, busy, done;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  lf_downlink_enc #(.DIV(DIV), .START_FC(SG), .GAP_FC(GP), .ZERO_FC(Z0),
    .ONE_FC(O1), .HOLD_FC(HD), .SETTLE_FC(ST)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_op(cmd_op), .pw_en(pw_en),
    .pw_value(pw_value), .wr_data(wr_data), .blk_addr(blk_addr),
    .field_en(field_en), .busy(busy), .done(done));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected frame from R4, R5, R6, right-aligned
  function automatic void expect_frame(input vec_t v, output logic [69:0] e, output int n);
    e = 70'd0; n = 0;
    if (v.op == 2'd2) begin
      e = 70'b11; n = 2;
    end else begin
      e = 70'b10; n = 2;
      if (v.pen) begin e = (e << 32) | 70'(v.pw); n += 32; end
      e = e << 1; n += 1;
      if (v.op == 2'd0) begin e = (e << 32) | 70'(v.data); n += 32; end
      e = (e << 3) | 70'(v.blk); n += 3;
    end
  endfunction

  task automatic run_cmd(input vec_t v, input bit poke);
    logic [69:0] exp_bits, got;
    int elen, k, n, gap_bad, len_bad;
    expect_frame(v, exp_bits, elen);
    @(negedge clk);
    cmd_op = v.op; pw_en = v.pen; pw_value = v.pw; wr_data = v.data; blk_addr = v.blk;
    start = 1;
    @(negedge clk);
    start = 0;
    check(busy == 1'b1, "R2 busy after accept", busy, 1);
    n = 0;
    while (field_en == 1'b0) begin
      n++;
      if (poke && n == 2) begin
        start = 1; cmd_op = 2'd1; wr_data = ~v.data; pw_value = ~v.pw; blk_addr = ~v.blk;
      end
      if (poke && n == 3) start = 0;
      @(negedge clk);
    end
    check(n == SG * DIV, "R2/R9 start gap length", n, SG * DIV);
    got = 0; k = 0; gap_bad = 0; len_bad = 0;
    for (int i = 0; i < elen; i++) begin
      n = 0;
      while (field_en == 1'b1) begin n++; @(negedge clk); end
      if (n == O1 * DIV) got = (got << 1) | 70'd1;
      else if (n == Z0 * DIV) got = got << 1;
      else len_bad++;
      k++;
      n = 0;
      while (field_en == 1'b0) begin n++; @(negedge clk); end
      if (n != GP * DIV) gap_bad++;
    end
    check(len_bad == 0, "R3 bit on-interval lengths", len_bad, 0);
    check(gap_bad == 0, "R3 inter-bit gap lengths", gap_bad, 0);
    check(got == exp_bits && k == elen, "R4/R5/R6/R10 decoded frame", got, exp_bits);
    n = 0;
    while (done == 1'b0) begin
      if (field_en) n++;
      @(negedge clk);
    end
    if (v.op == 2'd0) begin
      check(n == HD * DIV, "R7 program hold length", n, HD * DIV);
      check(field_en == 1'b0, "R7 field off at done", field_en, 0);
    end else begin
      check(n == ST * DIV, "R8 settle length", n, ST * DIV);
      check(field_en == 1'b1, "R8 field on at done", field_en, 1);
    end
    check(busy == 1'b0, "R12 busy low with done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R12 done single cycle", done, 0);
    check(field_en == (v.op != 2'd0), "R7/R8 idle field level", field_en, v.op != 2'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(field_en == 0 && busy == 0 && done == 0, "R1 reset state",
          {field_en, busy, done}, 0);
    rst_n = 1;
    @(negedge clk);
    check(field_en == 0 && busy == 0, "R1 idle after reset", {field_en, busy}, 0);

    for (int i = 0; i < NV; i++) run_cmd(VEC[i], 1'b0);

    // R11: reserved op while field is on after a read
    @(negedge clk);
    cmd_op = 2'd3; start = 1;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    check(busy == 1'b0, "R11 reserved op not accepted", busy, 0);
    check(field_en == 1'b1, "R11 field level kept", field_en, 1);

    // R10: start pulse and input changes mid-frame are ignored
    run_cmd(VEC[0], 1'b1);
    run_cmd(VEC[3], 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule